// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block holds a configuration bitstream in a small on-chip ROM and shifts it out one bit at a time to a programmable-logic target. An internal bit-position counter selects the bit on the serial data output. Each rising edge of the serial clock moves the counter forward by one position, so the next bit appears on the data line. The ROM contents come from a parameter.

The serial clock has two modes. In master mode the block generates the clock from the system clock through a parameterised divider and drives it on the clock output. In slave mode, used when the block is not the first one in a chain, the clock arrives on an input. That input is sampled by a two-flop synchroniser, and its rising edges advance the counter.

An active-high enable input also serves as the counter's active-low reset. An active-low select gates both the data drive and the counting. Once the whole stream has been sent, a done flag rises. The data pin then either drives high or floats, depending on a parameter.

Top module: `cfg_bit_streamer`

## Requirements
- R1: At every system clock edge that sees `oe_i` low, the bit position returns to zero and `done_o` clears. While `oe_i` is low, `sdata_oe_o` is 0. When `oe_i` goes high again, the stream restarts at bit 0.
- R2: In master mode, `sclk_oe_o` is always 1. While `oe_i` is low, `sclk_o` is 0.
- R3: While `cs_n_i` is high, `sdata_oe_o` is 0, whatever the other inputs and the progress of the stream.
- R4: Bit position p carries bit (p mod 8) of stored byte p/8, where byte 0 is `ROM_INIT[7:0]`, so each byte is sent least significant bit first. While streaming, `sdata_oe_o` is 1. The bit at the current position appears on `sdata_o` in the same cycle that `oe_i` is high, `cs_n_i` is low and the stream is unfinished.
- R5: In master mode, each rising edge of `sclk_o` advances the position by exactly one. The advance takes effect one system clock after `sclk_o` rises, which gives the target hold time. An uninterrupted run produces exactly `NUM_BITS` rising edges.
- R6: While `cs_n_i` is high, the position holds and the master clock stays low. When `cs_n_i` returns low, streaming resumes from the held position.
- R7: `done_o` is 1 exactly when the position equals `NUM_BITS`. Once set, the position no longer moves, and `done_o` stays 1 until the next edge that sees `oe_i` low.
- R8: After completion, with `oe_i` high and `cs_n_i` low, the data pin depends on `DONE_DRIVE_HIGH`. If it is 1, `sdata_oe_o` is 1 and `sdata_o` is 1. If it is 0, `sdata_oe_o` is 0.
- R9: In master mode, `sclk_o` is 0 after completion.
- R10: In master mode, once streaming is enabled, `sclk_o` stays low for `CLK_DIV` system cycles. It then alternates between `CLK_DIV` cycles high and `CLK_DIV` cycles low for as long as streaming stays enabled.
- R11: In slave mode, `sclk_oe_o` and `sclk_o` are 0. A rising edge on `sclk_i` is one where `sclk_i` is sampled high at system edge k after being sampled low at edge k-1. Such an edge advances the position at edge k+2, provided streaming is enabled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| oe_i | input | 1 | Output enable; low level resets the bit position |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock input (slave mode) |
| sclk_o | output | 1 | Serial clock output value (master mode) |
| sclk_oe_o | output | 1 | Drive enable of the serial clock pin |
| sdata_o | output | 1 | Serial data output value |
| sdata_oe_o | output | 1 | Drive enable of the serial data pin |
| done_o | output | 1 | All configuration bits have been sent |

## Verification
The bench goes after several corner cases.

- **Pausing just after a clock rise.** Select is dropped right after a clock rise while an advance is still pending. A design that keeps that pending step would skip a bit when streaming resumes.
- **Hold timing.** A design that advances on the same system edge as the clock rise would change the data together with the clock. The bench catches this in master mode.
- **End of stream.** At the last bit, the bench checks that the clock falls, that done holds, and that the data pin parks correctly in both parking options. An off-by-one counter limit would emit one bit too many or one too few.
- **Enable dropped mid-stream.** A counter that is not cleared would restart somewhere other than bit 0.
- **Slave synchroniser latency.** The bench checks the advance latency against the synchroniser depth. A design with the wrong latency would put each bit on the pin a cycle early or late.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_STREAM = 2'd1,
      ST_PAUSE  = 2'd2,
      ST_DONE   = 2'd3
   } cbs_state_e;

   // Counter width able to hold the value n; never below 4 so that the
   // byte-select slice of the bit position is always at least one bit wide.
   function automatic int unsigned pos_width(input int unsigned n);
      int unsigned w;
      w = $clog2(n + 1);
      return (w < 4) ? 4 : w;
   endfunction

endpackage

// File: rtl/cbs_bit_rom.sv
module cbs_bit_rom #(
   parameter int unsigned NUM_BITS = 40,
   parameter int unsigned AW       = 6,
   parameter int unsigned NBYTES   = 5,
   parameter logic [8*NBYTES-1:0] INIT = '0
) (
   input  logic [AW-1:0] pos_i,
   output logic          bit_o
);

   localparam int unsigned SW = AW - 3;

   logic [7:0] rom_byte [NBYTES];

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign rom_byte[b] = INIT[8*b +: 8];
   end

   if (NBYTES * 8 < NUM_BITS) begin : g_size_bad
      $error("cbs_bit_rom: storage smaller than bitstream");
   end

   logic [SW-1:0] byte_sel;
   logic [2:0]    bit_sel;

   assign byte_sel = pos_i[AW-1:3];
   assign bit_sel  = pos_i[2:0];

   always_comb begin
      bit_o = 1'b0;
      for (int b = 0; b < int'(NBYTES); b++) begin
         if (byte_sel == SW'(b)) begin
            bit_o = rom_byte[b][bit_sel];
         end
      end
   end

endmodule

// File: rtl/cbs_clk_src.sv
module cbs_clk_src #(
   parameter bit          MASTER  = 1'b1,
   parameter int unsigned CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic sclk_i,
   output logic sclk_o,
   output logic sclk_oe_o,
   output logic adv_o
);

   if (MASTER) begin : g_master
      localparam int unsigned DW = (CLK_DIV < 2) ? 1 : $clog2(CLK_DIV);
      localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

      if (CLK_DIV < 2) begin : g_div_bad
         $error("cbs_clk_src: CLK_DIV must be at least 2");
      end

      logic [DW-1:0] div_q;
      logic          sclk_q;
      logic          adv_q;
      logic          unused_sclk_in;

      assign unused_sclk_in = sclk_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
            adv_q  <= 1'b0;
         end else if (!run_i) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
            adv_q  <= 1'b0;
         end else begin
            // advance one system clock after the rising edge leaves the pin
            adv_q <= (div_q == LAST) && !sclk_q;
            if (div_q == LAST) begin
               div_q  <= '0;
               sclk_q <= ~sclk_q;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
      end

      assign sclk_o    = sclk_q & run_i;
      assign sclk_oe_o = 1'b1;
      assign adv_o     = adv_q;

      p_clk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !run_i |=> !sclk_q);

   end else begin : g_slave
      logic s1_q, s2_q, s3_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
         end else begin
            s1_q <= sclk_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
         end
      end

      assign sclk_o    = 1'b0;
      assign sclk_oe_o = 1'b0;
      assign adv_o     = s2_q & ~s3_q & run_i;
   end

endmodule

// File: rtl/cbs_pos_ctr.sv
module cbs_pos_ctr #(
   parameter int unsigned NUM_BITS = 40,
   parameter int unsigned AW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          oe_i,
   input  logic          cs_n_i,
   input  logic          adv_i,
   output logic [AW-1:0] pos_o,
   output logic          done_o
);

   localparam logic [AW-1:0] END_POS = AW'(NUM_BITS);

   logic [AW-1:0] pos_q;

   assign done_o = (pos_q == END_POS);
   assign pos_o  = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (!oe_i) begin
         pos_q <= '0;
      end else if (adv_i && !cs_n_i && !done_o) begin
         pos_q <= pos_q + 1'b1;
      end
   end

   p_oe_low_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_i |=> (pos_q == '0));

   p_hold_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_i && cs_n_i) |=> (pos_q == $past(pos_q)));

   p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_i |=> ((pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + 1'b1)));

   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && oe_i) |=> done_o);

   p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= END_POS);

endmodule

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer
   import cbs_pkg::*;
#(
   parameter int unsigned NUM_BITS        = 40,
   parameter logic [8*((NUM_BITS+7)/8)-1:0] ROM_INIT = 40'hE1_96_0F_3C_A5,
   parameter bit          MASTER          = 1'b1,
   parameter int unsigned CLK_DIV         = 4,
   parameter bit          DONE_DRIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oe_i,
   input  logic cs_n_i,
   input  logic sclk_i,
   output logic sclk_o,
   output logic sclk_oe_o,
   output logic sdata_o,
   output logic sdata_oe_o,
   output logic done_o
);

   localparam int unsigned NBYTES = (NUM_BITS + 7) / 8;
   localparam int unsigned AW     = pos_width(NUM_BITS);

   if (NUM_BITS < 1) begin : g_len_bad
      $error("cfg_bit_streamer: NUM_BITS must be positive");
   end

   logic [AW-1:0] pos;
   logic          done;
   logic          adv;
   logic          rom_bit;
   logic          run;
   logic          park_drive;
   cbs_state_e    st;

   always_comb begin
      if (!oe_i) begin
         st = ST_IDLE;
      end else if (done) begin
         st = ST_DONE;
      end else if (cs_n_i) begin
         st = ST_PAUSE;
      end else begin
         st = ST_STREAM;
      end
   end

   assign run = (st == ST_STREAM);

   cbs_clk_src #(
      .MASTER  (MASTER),
      .CLK_DIV (CLK_DIV)
   ) u_clk_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .sclk_i    (sclk_i),
      .sclk_o    (sclk_o),
      .sclk_oe_o (sclk_oe_o),
      .adv_o     (adv)
   );

   cbs_pos_ctr #(
      .NUM_BITS (NUM_BITS),
      .AW       (AW)
   ) u_pos_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .oe_i   (oe_i),
      .cs_n_i (cs_n_i),
      .adv_i  (adv),
      .pos_o  (pos),
      .done_o (done)
   );

   cbs_bit_rom #(
      .NUM_BITS (NUM_BITS),
      .AW       (AW),
      .NBYTES   (NBYTES),
      .INIT     (ROM_INIT)
   ) u_bit_rom (
      .pos_i (pos),
      .bit_o (rom_bit)
   );

   if (DONE_DRIVE_HIGH) begin : g_park_high
      assign park_drive = (st == ST_DONE) && !cs_n_i;
   end else begin : g_park_float
      assign park_drive = 1'b0;
   end

   assign sdata_oe_o = run | park_drive;
   assign sdata_o    = run ? rom_bit : park_drive;
   assign done_o     = done;

endmodule

// File: tb/cfg_bit_streamer_tb.sv
module cfg_bit_streamer_tb;

   localparam int unsigned N   = 20;
   localparam int unsigned DIV = 2;
   localparam logic [23:0] ROM = 24'h3C_A5_D6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic oe = 1'b0;
   logic cs_n = 1'b1;
   logic sclk_s = 1'b0;
   logic slv_run = 1'b0;

   logic sclk_m, sclk_oe_m, sdata_m, sdata_oe_m, done_m;
   logic sclk_so, sclk_oe_s, sdata_s, sdata_oe_s, done_s;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rises = 0;
   bit cnt_on = 1'b0;
   bit prev_m = 1'b0;
   string ptag = "R4";

   always #5 clk = ~clk;

   cfg_bit_streamer #(
      .NUM_BITS (N), .ROM_INIT (ROM), .MASTER (1'b1),
      .CLK_DIV (DIV), .DONE_DRIVE_HIGH (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .oe_i (oe), .cs_n_i (cs_n), .sclk_i (1'b0),
      .sclk_o (sclk_m), .sclk_oe_o (sclk_oe_m), .sdata_o (sdata_m),
      .sdata_oe_o (sdata_oe_m), .done_o (done_m)
   );

   cfg_bit_streamer #(
      .NUM_BITS (N), .ROM_INIT (ROM), .MASTER (1'b0),
      .CLK_DIV (DIV), .DONE_DRIVE_HIGH (1'b0)
   ) u_dut_slv (
      .clk (clk), .rst_n (rst_n), .oe_i (oe), .cs_n_i (cs_n), .sclk_i (sclk_s),
      .sclk_o (sclk_so), .sclk_oe_o (sclk_oe_s), .sdata_o (sdata_s),
      .sdata_oe_o (sdata_oe_s), .done_o (done_s)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   function automatic logic ref_bit(input int p);
      logic [7:0] by;
      by = ROM[8*(p/8) +: 8];
      return by[p%8];
   endfunction

   // behavioural reference models
   int m_pos = 0;
   int m_ph = 0;
   bit m_pend = 1'b0;
   int s_pos = 0;
   bit sq[$] = '{1'b0, 1'b0, 1'b0};

   always @(posedge clk) begin
      bit en_m, en_s, rise_s, dn_m, dn_s;
      string t_oe, t_dat, t_clk;
      if (!rst_n) begin
         m_pos = 0; m_ph = 0; m_pend = 1'b0; s_pos = 0;
         sq = '{1'b0, 1'b0, 1'b0};
      end else begin
         en_m = oe && !cs_n && (m_pos < N);
         if (!oe) m_pos = 0;
         else if (en_m && m_pend) m_pos++;
         if (!en_m) begin
            m_ph = 0; m_pend = 1'b0;
         end else begin
            m_pend = (m_ph == DIV - 1);
            m_ph = (m_ph + 1) % (2 * DIV);
         end
         en_s = oe && !cs_n && (s_pos < N);
         rise_s = sq[1] && !sq[2];
         if (!oe) s_pos = 0;
         else if (en_s && rise_s) s_pos++;
         sq.push_front(sclk_s);
         void'(sq.pop_back());
      end
      #2;
      en_m = oe && !cs_n && (m_pos < N);
      dn_m = (m_pos == N);
      en_s = oe && !cs_n && (s_pos < N);
      dn_s = (s_pos == N);
      t_oe  = !oe ? "R1" : (cs_n ? "R3" : (dn_m ? "R8" : "R4"));
      t_dat = en_m ? ptag : (dn_m ? "R8" : "R1");
      t_clk = !oe ? "R2" : (dn_m ? "R9" : (cs_n ? "R6" : "R10"));
      chk(t_oe, sdata_oe_m, oe && !cs_n);
      chk(t_dat, sdata_m, en_m ? ref_bit(m_pos) : (oe && !cs_n && dn_m));
      chk(t_clk, sclk_m, en_m && (m_ph >= DIV));
      chk("R2", sclk_oe_m, 1'b1);
      chk("R7", done_m, dn_m);
      chk(dn_s ? "R8" : "R11", sdata_oe_s, en_s);
      chk("R11", sdata_s, en_s ? ref_bit(s_pos) : 1'b0);
      chk("R11", sclk_oe_s, 1'b0);
      chk("R11", sclk_so, 1'b0);
      chk("R7", done_s, dn_s);
      if (!cnt_on) rises = 0;
      else if (sclk_m && !prev_m) rises++;
      prev_m = sclk_m;
   end

   // slave clock source: toggles every 3 system cycles
   int tcnt = 0;
   always @(negedge clk) begin
      if (slv_run) begin
         tcnt++;
         if (tcnt == 3) begin
            tcnt = 0;
            sclk_s <= ~sclk_s;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", done_m, 1'b0);
      chk("R1", sdata_oe_m, 1'b0);
      chk("R2", sclk_m, 1'b0);
      chk("R1", done_s, 1'b0);

      oe = 1'b1;
      repeat (4) @(negedge clk);
      chk("R3", sdata_oe_m, 1'b0);
      chk("R3", sdata_oe_s, 1'b0);

      cs_n = 1'b0;
      slv_run = 1'b1;
      #1;
      chk("R4", sdata_oe_m, 1'b1);
      chk("R4", sdata_m, ref_bit(0));
      repeat (25) @(negedge clk);

      cs_n = 1'b1;
      ptag = "R6";
      repeat (8) @(negedge clk);
      chk("R3", sdata_oe_m, 1'b0);
      chk("R6", sclk_m, 1'b0);
      cs_n = 1'b0;
      while (!(done_m && done_s)) @(negedge clk);
      ptag = "R4";

      chk("R7", done_m, 1'b1);
      chk("R8", sdata_m, 1'b1);
      chk("R8", sdata_oe_m, 1'b1);
      chk("R8", sdata_oe_s, 1'b0);
      chk("R9", sclk_m, 1'b0);
      repeat (5) @(negedge clk);
      chk("R7", done_m, 1'b1);
      cs_n = 1'b1;
      #1;
      chk("R3", sdata_oe_m, 1'b0);
      cs_n = 1'b0;

      @(negedge clk);
      oe = 1'b0;
      @(negedge clk);
      chk("R1", done_m, 1'b0);
      chk("R1", sdata_oe_m, 1'b0);
      chk("R2", sclk_m, 1'b0);

      oe = 1'b1;
      cnt_on = 1'b1;
      ptag = "R5";
      while (!done_m) @(negedge clk);
      chk_int("R5", rises, N);
      cnt_on = 1'b0;
      ptag = "R4";

      oe = 1'b0;
      @(negedge clk);
      oe = 1'b1;
      repeat (9) @(negedge clk);
      oe = 1'b0;
      @(negedge clk);
      chk("R1", done_m, 1'b0);
      oe = 1'b1;
      #1;
      chk("R1", sdata_m, ref_bit(0));
      repeat (6) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule